// File: doc/BRIEF.md
# Interlocked Two-Mode Word Transfer Port

This block moves one parallel word at a time from a sending side to a receiving side. The control lines between the two sides are not tied to a common clock. Both sides live in the block. Each has a small synchronous user interface. The sender takes a word and a start pulse and gives back a completion pulse. The receiver takes a request pulse and gives back the captured word and a completion pulse. The link lines leave and re-enter the block through ports. A system can therefore wire them to a remote peer, or loop them back.

A mode input picks which side opens a transfer.
- In sender-led transfers, the sender drives the word, then raises its strobe. The receiver captures the word and answers on its own line.
- In receiver-led transfers, the receiver raises a request first. The sender then drives the word and raises its strobe to say the word is present. The receiver captures the word when it sees that strobe.

In both modes the answering line comes from the side that did not open the transfer. Completion therefore never relies on a known response time. All four line phases run to completion, so every line is back low before the next word.

Each incoming control line crosses a two-flop synchronizer before either state machine looks at it. The sender keeps the word on the link for a programmed number of local cycles before its strobe rises. After it sees the answer, it keeps the word for a second programmed count before it takes the word away.

Top module: `hs_xfer_port`

## Requirements
- R1: While reset is held, `lnk_data_o` is zero, `lnk_src_ctl_o`, `lnk_dst_ctl_o`, `src_done_o` and `dst_done_o` are low, and `dst_word_o` is zero.
- R2: With `mode_i` = 0 (sender-led), a `src_start_i` pulse puts `src_word_i` on `lnk_data_o`. `lnk_src_ctl_o` rises no sooner than `SETUP_CYC` cycles after that word appears, and the word does not change while `lnk_src_ctl_o` is high.
- R3: With `mode_i` = 0, when the receiver sees `lnk_src_ctl_i` high after synchronization, it loads `lnk_data_i` into `dst_word_o` and raises `lnk_dst_ctl_o` on the same edge.
- R4: With `mode_i` = 0, the sender keeps its word until at least `HOLD_CYC`+2 cycles after `lnk_dst_ctl_i` rises. It then lowers `lnk_src_ctl_o` and returns `lnk_data_o` to zero. `src_done_o` pulses for one cycle once the answer line is seen low again. `dst_done_o` pulses for one cycle once the strobe is seen low.
- R5: With `mode_i` = 1 (receiver-led), `dst_start_i` raises `lnk_dst_ctl_o`. A sender armed by `src_start_i` responds to the request: it drives its word, and raises `lnk_src_ctl_o` no sooner than `SETUP_CYC` cycles later. The word stays constant while `lnk_src_ctl_o` is high. An armed sender drives nothing until the request arrives.
- R6: With `mode_i` = 1, the receiver loads `lnk_data_i` into `dst_word_o` and lowers its request when it sees the strobe high. The sender keeps the word for at least `HOLD_CYC`+2 cycles after the request falls. It then lowers its strobe and clears the data, pulsing `src_done_o`. `dst_done_o` pulses once the strobe is seen low.
- R7: Four-phase interlock. A side that has answered keeps its answer high for as long as the opening line stays high. A start request is ignored while the opposite side's line is still seen high. Whenever both sides are idle, both control lines are low.
- R8: `mode_i` is taken into the block only on cycles where both sides are idle. A change during a transfer affects neither that transfer nor any line, and applies to the next transfer.
- R9: `src_start_i` is ignored while the sender is busy. `dst_start_i` is ignored in sender-led mode.
- R10: A control input acts through two synchronizer flops. When `lnk_src_ctl_i` changes just after an edge, the receiver's response on `lnk_dst_ctl_o` appears on the third rising edge after the change, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock for both sides |
| rst_n | input | 1 | Active-low reset |
| mode_i | input | 1 | 0 = sender-led, 1 = receiver-led |
| src_start_i | input | 1 | Sender start / arm pulse |
| src_word_i | input | WORD_W | Word to send, taken with the start pulse |
| src_done_o | output | 1 | One-cycle pulse when the sender's transfer ends |
| dst_start_i | input | 1 | Receiver request pulse (receiver-led mode only) |
| dst_word_o | output | WORD_W | Last captured word |
| dst_done_o | output | 1 | One-cycle pulse when the receiver's transfer ends |
| lnk_data_o | output | WORD_W | Link data driven by the sender, zero when not driving |
| lnk_src_ctl_o | output | 1 | Sender strobe (ready in sender-led, valid in receiver-led) |
| lnk_dst_ctl_i | input | 1 | Receiver line as seen by the sender |
| lnk_data_i | input | WORD_W | Link data as seen by the receiver |
| lnk_src_ctl_i | input | 1 | Sender strobe as seen by the receiver |
| lnk_dst_ctl_o | output | 1 | Receiver line (acknowledge in sender-led, request in receiver-led) |

## Verification
The hardest conditions to reach are those that a well-behaved peer never creates. Examples are an answer line that is already high when a start arrives, an opening strobe that is held far longer than the interlock needs, and the exact edge on which a synchronized change first takes effect. The loopback that normal traffic uses cannot produce them. The bench therefore cuts the loopback and drives the incoming link lines itself, at chosen cycle offsets. It then counts edges up to the first visible response. A mid-transfer mode flip is applied while the loopback is active, so the in-flight transfer and the following one can each be judged by their line behaviour.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;

    localparam logic MODE_SRC_LED = 1'b0;
    localparam logic MODE_DST_LED = 1'b1;

    typedef enum logic [2:0] {
        SS_IDLE,
        SS_ARMED,
        SS_SETUP,
        SS_ANSWER,
        SS_HOLD,
        SS_CLOSE
    } src_st_e;

    typedef enum logic [1:0] {
        DS_IDLE,
        DS_REQ,
        DS_CLOSE
    } dst_st_e;

endpackage

// File: rtl/hs_sync2.sv
`timescale 1ns/1ps
module hs_sync2 #(
    parameter int N = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);

    for (genvar g = 0; g < N; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= d_i[g];
                sync_q <= meta_q;
            end
        end
        assign q_o[g] = sync_q;
    end

endmodule

// File: rtl/hs_src_fsm.sv
`timescale 1ns/1ps
module hs_src_fsm
    import hs_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] word_i,
    input  logic              peer_s_i,
    output logic [WORD_W-1:0] data_o,
    output logic              ctl_o,
    output logic              done_o,
    output logic              idle_o
);

    localparam int MAXC = (SETUP_CYC > HOLD_CYC) ? SETUP_CYC : HOLD_CYC;
    localparam int CW   = $clog2(MAXC + 2);
    localparam logic [CW-1:0] SETUP_N = CW'(SETUP_CYC);
    localparam logic [CW-1:0] HOLD_N  = CW'(HOLD_CYC);

    typedef struct packed {
        src_st_e           st;
        logic [CW-1:0]     cnt;
        logic [WORD_W-1:0] word;
        logic              drive;
        logic              ctl;
        logic              done;
    } src_reg_t;

    src_reg_t r_q, r_d;
    logic     answered;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        answered = (mode_i == MODE_SRC_LED) ? peer_s_i : !peer_s_i;
        case (r_q.st)
            SS_IDLE: begin
                if (start_i && (mode_i == MODE_DST_LED || !peer_s_i)) begin
                    r_d.word = word_i;
                    if (mode_i == MODE_SRC_LED) begin
                        r_d.drive = 1'b1;
                        r_d.cnt   = SETUP_N;
                        r_d.st    = SS_SETUP;
                    end else begin
                        r_d.st    = SS_ARMED;
                    end
                end
            end
            SS_ARMED: begin
                if (peer_s_i) begin
                    r_d.drive = 1'b1;
                    r_d.cnt   = SETUP_N;
                    r_d.st    = SS_SETUP;
                end
            end
            SS_SETUP: begin
                if (r_q.cnt == '0) begin
                    r_d.ctl = 1'b1;
                    r_d.st  = SS_ANSWER;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SS_ANSWER: begin
                if (answered) begin
                    r_d.cnt = HOLD_N;
                    r_d.st  = SS_HOLD;
                end
            end
            SS_HOLD: begin
                if (r_q.cnt == '0) begin
                    r_d.ctl   = 1'b0;
                    r_d.drive = 1'b0;
                    if (mode_i == MODE_SRC_LED) begin
                        r_d.st = SS_CLOSE;
                    end else begin
                        r_d.done = 1'b1;
                        r_d.st   = SS_IDLE;
                    end
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                end
            end
            SS_CLOSE: begin
                if (!peer_s_i) begin
                    r_d.done = 1'b1;
                    r_d.st   = SS_IDLE;
                end
            end
            default: r_d.st = SS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: SS_IDLE, cnt: '0, word: '0, drive: 1'b0, ctl: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign data_o = r_q.drive ? r_q.word : '0;
    assign ctl_o  = r_q.ctl;
    assign done_o = r_q.done;
    assign idle_o = (r_q.st == SS_IDLE);

    // Checker state: cycles the word has been on the link, saturating.
    logic [CW:0] on_link_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            on_link_q <= '0;
        end else if (!r_q.drive) begin
            on_link_q <= '0;
        end else if (on_link_q != '1) begin
            on_link_q <= on_link_q + 1'b1;
        end
    end

    // R2 / R5: the strobe never rises before the setup window has elapsed.
    a_r2_setup_window: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ctl_o) |-> (on_link_q >= {1'b0, SETUP_N}));

    // R2 / R5: the word is frozen while the strobe is high.
    a_r5_word_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_o && $past(ctl_o)) |-> $stable(data_o));

    // R4: in sender-led mode the strobe is only released after the answer is seen.
    a_r4_release_after_ack: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_o) && mode_i == MODE_SRC_LED) |-> peer_s_i);

    // R4 / R6: completion is a single-cycle pulse.
    a_r4_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/hs_dst_fsm.sv
`timescale 1ns/1ps
module hs_dst_fsm
    import hs_pkg::*;
#(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              start_i,
    input  logic [WORD_W-1:0] data_i,
    input  logic              peer_s_i,
    output logic [WORD_W-1:0] word_o,
    output logic              ctl_o,
    output logic              done_o,
    output logic              idle_o
);

    typedef struct packed {
        dst_st_e           st;
        logic [WORD_W-1:0] word;
        logic              ctl;
        logic              done;
    } dst_reg_t;

    dst_reg_t r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        case (r_q.st)
            DS_IDLE: begin
                if (mode_i == MODE_SRC_LED) begin
                    if (peer_s_i) begin
                        r_d.word = data_i;
                        r_d.ctl  = 1'b1;
                        r_d.st   = DS_CLOSE;
                    end
                end else if (start_i && !peer_s_i) begin
                    r_d.ctl = 1'b1;
                    r_d.st  = DS_REQ;
                end
            end
            DS_REQ: begin
                if (peer_s_i) begin
                    r_d.word = data_i;
                    r_d.ctl  = 1'b0;
                    r_d.st   = DS_CLOSE;
                end
            end
            DS_CLOSE: begin
                if (!peer_s_i) begin
                    r_d.ctl  = 1'b0;
                    r_d.done = 1'b1;
                    r_d.st   = DS_IDLE;
                end
            end
            default: r_d.st = DS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: DS_IDLE, word: '0, ctl: 1'b0, done: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign word_o = r_q.word;
    assign ctl_o  = r_q.ctl;
    assign done_o = r_q.done;
    assign idle_o = (r_q.st == DS_IDLE);

    // R3: the acknowledge only rises while the synchronized strobe is high.
    a_r3_ack_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(ctl_o) && mode_i == MODE_SRC_LED) |-> peer_s_i);

    // R6: the request is only withdrawn once the strobe has been seen.
    a_r6_req_drop_on_valid: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ctl_o) && mode_i == MODE_DST_LED) |-> peer_s_i);

    // R7: an acknowledge is held for as long as the strobe stays high.
    a_r7_ack_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_SRC_LED && ctl_o && peer_s_i) |=> ctl_o);

    // R4 / R6: completion is a single-cycle pulse.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

endmodule

// File: rtl/hs_xfer_port.sv
`timescale 1ns/1ps
module hs_xfer_port
    import hs_pkg::*;
#(
    parameter int WORD_W    = 8,
    parameter int SETUP_CYC = 2,
    parameter int HOLD_CYC  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_i,
    input  logic              src_start_i,
    input  logic [WORD_W-1:0] src_word_i,
    output logic              src_done_o,
    input  logic              dst_start_i,
    output logic [WORD_W-1:0] dst_word_o,
    output logic              dst_done_o,
    output logic [WORD_W-1:0] lnk_data_o,
    output logic              lnk_src_ctl_o,
    input  logic              lnk_dst_ctl_i,
    input  logic [WORD_W-1:0] lnk_data_i,
    input  logic              lnk_src_ctl_i,
    output logic              lnk_dst_ctl_o
);

    localparam int NSYNC = 2;

    typedef struct packed {
        logic mode;
    } top_reg_t;

    top_reg_t         r_q, r_d;
    logic [NSYNC-1:0] ctl_raw;
    logic [NSYNC-1:0] ctl_s;
    logic             src_idle;
    logic             dst_idle;

    assign ctl_raw = {lnk_src_ctl_i, lnk_dst_ctl_i};

    hs_sync2 #(.N(NSYNC)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (ctl_raw),
        .q_o   (ctl_s)
    );

    always_comb begin
        r_d = r_q;
        if (src_idle && dst_idle) begin
            r_d.mode = mode_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{mode: MODE_SRC_LED};
        end else begin
            r_q <= r_d;
        end
    end

    hs_src_fsm #(
        .WORD_W    (WORD_W),
        .SETUP_CYC (SETUP_CYC),
        .HOLD_CYC  (HOLD_CYC)
    ) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (r_q.mode),
        .start_i  (src_start_i),
        .word_i   (src_word_i),
        .peer_s_i (ctl_s[0]),
        .data_o   (lnk_data_o),
        .ctl_o    (lnk_src_ctl_o),
        .done_o   (src_done_o),
        .idle_o   (src_idle)
    );

    hs_dst_fsm #(
        .WORD_W (WORD_W)
    ) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .mode_i   (r_q.mode),
        .start_i  (dst_start_i),
        .data_i   (lnk_data_i),
        .peer_s_i (ctl_s[1]),
        .word_o   (dst_word_o),
        .ctl_o    (lnk_dst_ctl_o),
        .done_o   (dst_done_o),
        .idle_o   (dst_idle)
    );

    // R8: the latched mode never moves while either side is in a transfer.
    a_r8_mode_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !(src_idle && dst_idle) |=> $stable(r_q.mode));

    // R7: with both sides idle, both control lines are low.
    a_r7_idle_lines_low: assert property (@(posedge clk) disable iff (!rst_n)
        (src_idle && dst_idle) |-> (!lnk_src_ctl_o && !lnk_dst_ctl_o));

endmodule

// File: tb/sim_hs_xfer_port.sv
`timescale 1ns/1ps
module sim_hs_xfer_port;

    localparam int W     = 8;
    localparam int SETUP = 2;
    localparam int HOLD  = 2;
    localparam int NV    = 6;
    // {mode, word}: mode 0 = sender-led, 1 = receiver-led
    localparam logic [8:0] VEC [NV] = '{9'h03C, 9'h0FF, 9'h001, 9'h1A5, 9'h180, 9'h17E};

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         mode_i = 1'b0;
    logic         src_start_i = 1'b0;
    logic [W-1:0] src_word_i = '0;
    logic         src_done_o;
    logic         dst_start_i = 1'b0;
    logic [W-1:0] dst_word_o;
    logic         dst_done_o;
    logic [W-1:0] lnk_data_o;
    logic         lnk_src_ctl_o;
    logic         lnk_dst_ctl_o;
    logic         loop_en = 1'b0;
    logic [W-1:0] m_data = '0;
    logic         m_sctl = 1'b0;
    logic         m_dctl = 1'b0;
    logic [W-1:0] lnk_data_i;
    logic         lnk_src_ctl_i;
    logic         lnk_dst_ctl_i;

    int n_checks = 0;
    int n_fail   = 0;
    int cyc      = 0;

    assign lnk_data_i    = loop_en ? lnk_data_o    : m_data;
    assign lnk_src_ctl_i = loop_en ? lnk_src_ctl_o : m_sctl;
    assign lnk_dst_ctl_i = loop_en ? lnk_dst_ctl_o : m_dctl;

    always #2.5 clk = ~clk;

    hs_xfer_port #(.WORD_W(W), .SETUP_CYC(SETUP), .HOLD_CYC(HOLD)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .mode_i        (mode_i),
        .src_start_i   (src_start_i),
        .src_word_i    (src_word_i),
        .src_done_o    (src_done_o),
        .dst_start_i   (dst_start_i),
        .dst_word_o    (dst_word_o),
        .dst_done_o    (dst_done_o),
        .lnk_data_o    (lnk_data_o),
        .lnk_src_ctl_o (lnk_src_ctl_o),
        .lnk_dst_ctl_i (lnk_dst_ctl_i),
        .lnk_data_i    (lnk_data_i),
        .lnk_src_ctl_i (lnk_src_ctl_i),
        .lnk_dst_ctl_o (lnk_dst_ctl_o)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog all-requirements actual=%0d expected=%0d", cyc, 150000);
            summary();
        end
    end

    task automatic wait_done(input bit use_src);
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (use_src ? src_done_o : dst_done_o) break;
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic run_xfer(input logic m, input logic [W-1:0] w);
        int    t_data = -1;
        int    t_ctl  = -1;
        int    t_ans  = -1;
        int    t_drop = -1;
        bit    sd = 0;
        bit    dd = 0;
        bit    unstable = 0;
        string rq = m ? "R5" : "R2";
        string rh = m ? "R6" : "R4";
        loop_en = 1'b1;
        mode_i  = m;
        repeat (2) @(negedge clk);
        src_word_i  = w;
        src_start_i = 1'b1;
        dst_start_i = m;
        @(negedge clk);
        src_start_i = 1'b0;
        dst_start_i = 1'b0;
        for (int t = 1; t <= 300 && !(sd && dd); t++) begin
            if (lnk_data_o == w && t_data < 0) t_data = t;
            if (lnk_src_ctl_o && t_ctl < 0) t_ctl = t;
            if (t_ans < 0 && ((m == 1'b0 && lnk_dst_ctl_o) || (m == 1'b1 && t_ctl >= 0 && !lnk_dst_ctl_o)))
                t_ans = t;
            if (t_ans >= 0 && t_drop < 0 && lnk_data_o != w) t_drop = t;
            if (lnk_src_ctl_o && lnk_data_o != w) unstable = 1'b1;
            if (src_done_o) sd = 1'b1;
            if (dst_done_o) dd = 1'b1;
            @(negedge clk);
        end
        repeat (2) @(negedge clk);
        chk(dst_word_o == w, m ? "R6" : "R3", "captured word", dst_word_o, w);
        chk(t_data >= 0 && t_ctl - t_data >= SETUP, rq, "setup cycles", t_ctl - t_data, SETUP);
        chk(!unstable, rq, "word stable under strobe", unstable, 0);
        chk(t_ans >= 0 && t_drop - t_ans >= HOLD + 2, rh, "hold after answer", t_drop - t_ans, HOLD + 2);
        chk(sd && dd, rh, "both done pulses", {sd, dd}, 3);
        chk(lnk_data_o == '0 && !lnk_src_ctl_o && !lnk_dst_ctl_o, "R7", "lines low after transfer",
            {lnk_src_ctl_o, lnk_dst_ctl_o}, 0);
    endtask

    initial begin
        bit seen_done;
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(lnk_data_o == '0 && dst_word_o == '0, "R1", "data at reset", lnk_data_o, 0);
        chk(!lnk_src_ctl_o && !lnk_dst_ctl_o && !src_done_o && !dst_done_o, "R1", "controls at reset",
            {lnk_src_ctl_o, lnk_dst_ctl_o, src_done_o, dst_done_o}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R10 / R3 / R7: receiver latency through the synchronizer, manual link
        loop_en = 1'b0;
        mode_i  = 1'b0;
        @(negedge clk);
        m_data = 8'hA5;
        m_sctl = 1'b1;
        repeat (2) @(negedge clk);
        chk(!lnk_dst_ctl_o, "R10", "ack before third edge", lnk_dst_ctl_o, 0);
        @(negedge clk);
        chk(lnk_dst_ctl_o, "R10", "ack on third edge", lnk_dst_ctl_o, 1);
        chk(dst_word_o == 8'hA5, "R3", "word captured with ack", dst_word_o, 8'hA5);
        seen_done = 1'b0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (dst_done_o) seen_done = 1'b1;
        end
        chk(lnk_dst_ctl_o && !seen_done, "R7", "ack held while strobe high", lnk_dst_ctl_o, 1);
        m_sctl = 1'b0;
        repeat (2) @(negedge clk);
        chk(lnk_dst_ctl_o, "R10", "ack release not before third edge", lnk_dst_ctl_o, 1);
        @(negedge clk);
        chk(!lnk_dst_ctl_o && dst_done_o, "R4", "ack low and receiver done", {lnk_dst_ctl_o, dst_done_o}, 1);

        // R7: sender start ignored while the answer line is still high
        m_dctl = 1'b1;
        repeat (3) @(negedge clk);
        src_word_i  = 8'h55;
        src_start_i = 1'b1;
        @(negedge clk);
        src_start_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(!lnk_src_ctl_o && lnk_data_o == '0, "R7", "start ignored with peer high", lnk_data_o, 0);
        m_dctl = 1'b0;
        repeat (4) @(negedge clk);

        // Table-driven transfers in both modes
        for (int i = 0; i < NV; i++) begin
            run_xfer(VEC[i][8], VEC[i][7:0]);
        end

        // R9: second start while busy is ignored
        loop_en = 1'b1;
        mode_i  = 1'b0;
        repeat (2) @(negedge clk);
        src_word_i  = 8'h11;
        src_start_i = 1'b1;
        @(negedge clk);
        src_word_i = 8'h22;
        @(negedge clk);
        src_start_i = 1'b0;
        wait_done(1'b1);
        chk(dst_word_o == 8'h11, "R9", "busy start ignored, word", dst_word_o, 8'h11);
        repeat (10) @(negedge clk);
        chk(!lnk_src_ctl_o && lnk_data_o == '0, "R9", "no second transfer", lnk_src_ctl_o, 0);

        // R9: receiver request ignored in sender-led mode
        dst_start_i = 1'b1;
        @(negedge clk);
        dst_start_i = 1'b0;
        repeat (6) @(negedge clk);
        chk(!lnk_dst_ctl_o, "R9", "request ignored in sender-led mode", lnk_dst_ctl_o, 0);

        // R8: mode flip mid-transfer applies only to the next transfer
        src_word_i  = 8'h33;
        src_start_i = 1'b1;
        @(negedge clk);
        src_start_i = 1'b0;
        mode_i = 1'b1;
        wait_done(1'b1);
        chk(dst_word_o == 8'h33, "R8", "in-flight transfer finished sender-led", dst_word_o, 8'h33);
        src_word_i  = 8'h44;
        src_start_i = 1'b1;
        @(negedge clk);
        src_start_i = 1'b0;
        repeat (10) @(negedge clk);
        chk(!lnk_src_ctl_o && lnk_data_o == '0, "R8", "armed sender waits for request", lnk_data_o, 0);
        dst_start_i = 1'b1;
        @(negedge clk);
        dst_start_i = 1'b0;
        wait_done(1'b0);
        chk(dst_word_o == 8'h44, "R8", "receiver-led transfer after flip", dst_word_o, 8'h44);

        summary();
    end

endmodule